// File: doc/BRIEF.md
# Interrupt Request Latch and Priority Resolver

This block is the front end of an eight-input interrupt controller. It samples the raw request lines every clock, turning each one into a stored request bit. A per-line trigger mode decides how: a line in edge mode remembers a low-to-high transition until something clears it, and a line in level mode simply mirrors its input. The trigger-mode register is written through a fixed write mask, so lines whose mask bit is zero can never leave edge mode.

The stored requests, minus the masked lines, go to a rotating priority search. The search starts at a programmable base line and moves upward, wrapping around. The winner is raised as pending only when it outranks every line currently in service, and the rank of each in-service line is measured with the same rotation. When the instance is the master and nested cascade mode is enabled, the in-service bit of the cascade line is left out of that comparison. The mask, in-service set, rotation base and nested flag are plain inputs supplied by a command decoder. An acknowledge or poll can drop one stored request through the clear port.

The pending outputs are a level status, not a data stream. They carry no handshake and cannot be back-pressured, because they always describe the current state. Priority evaluation is combinational from the stored requests and the control inputs.

Top module: `irq_latch_resolver`

## Requirements
- R1: A synchronous active-high reset clears every stored request, every remembered level and the trigger-mode register (all lines edge mode), so `pend_valid` is 0 after reset.
- R2: On a line in edge mode (`trig_mode` bit 0), the stored request bit is set at a clock edge where the input is 1 and the remembered previous level is 0. An input that stays high does not set it again after it has been cleared.
- R3: On an edge-mode line, a low input updates only the remembered level. It never clears a stored request bit.
- R4: On a line in level mode (`trig_mode` bit 1), the stored request bit takes the input value at every clock edge.
- R5: A write to the trigger-mode register stores `trig_wr_data & TRIG_WMASK`, with 8'hF8 on the master and 8'hDE on the slave. The new mode applies from the following edge.
- R6: The candidate set is the stored requests with the `irq_mask` bits removed. A masked line is never reported, and an empty candidate set gives `pend_valid` = 0.
- R7: The search order begins at line `rot_offset` and increases modulo 8. The first candidate in that order wins, and `pend_line` is (rank + `rot_offset`) mod 8.
- R8: `pend_valid` is 1 only when the winner's rank is strictly lower (higher priority) than the best-ranked in-service line, ranked with the same rotation. An empty in-service set counts as rank 8.
- R9: When `IS_MASTER` is 1 and `nested_en` is 1, in-service bit 2 is excluded from the R8 comparison. Otherwise it takes part.
- R10: With `clr_en` high, the stored request of line `clr_line` is 0 after the edge. This takes precedence over a set from either trigger mode in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | 8 | Raw request lines |
| trig_wr_en | input | 1 | Write strobe for the trigger-mode register |
| trig_wr_data | input | 8 | Trigger-mode write value (1 = level) |
| irq_mask | input | 8 | Per-line mask, 1 = masked |
| in_service | input | 8 | Lines currently being serviced |
| rot_offset | input | 3 | Line at which the priority search starts |
| nested_en | input | 1 | Nested cascade mode enable |
| clr_en | input | 1 | Drop one stored request this cycle |
| clr_line | input | 3 | Line whose request is dropped |
| trig_mode | output | 8 | Current trigger-mode register |
| req_latched | output | 8 | Current stored request bits |
| pend_valid | output | 1 | A request outranks everything in service |
| pend_line | output | 3 | Winning line number |

## Verification
The assertions take for granted that every input is at a known value at each clock edge from reset onward, and that `clr_line` addresses a real line. They also assume the in-service set is whatever the decoder presents, with no required relation to the stored requests. The stimulus changes inputs only at falling edges or between rising edges, and loads each request pattern through the ordinary capture path before sweeping mask, in-service, rotation and nested settings. During a sweep the stored requests are held steady by keeping the inputs constant.

// File: rtl/irqlr_pkg.sv
package irqlr_pkg;
  localparam int unsigned LINES_PER_UNIT = 8;
  localparam logic [7:0] MASTER_TRIG_WMASK = 8'hF8;
  localparam logic [7:0] SLAVE_TRIG_WMASK  = 8'hDE;
  localparam int unsigned CASCADE_LINE = 2;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/irqlr_capture.sv
module irqlr_capture
  import irqlr_pkg::*;
#(
  parameter int unsigned NLINES = LINES_PER_UNIT,
  parameter logic [NLINES-1:0] WMASK = MASTER_TRIG_WMASK,
  localparam int unsigned LW = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] req_in,
  input  logic              trig_wr_en,
  input  logic [NLINES-1:0] trig_wr_data,
  input  logic              clr_en,
  input  logic [LW-1:0]     clr_line,
  output logic [NLINES-1:0] trig_q,
  output logic [NLINES-1:0] irr_q
);
  logic [NLINES-1:0] last_q;
  logic [NLINES-1:0] irr_nxt;

  always_comb begin
    for (int i = 0; i < NLINES; i++) begin
      if (trig_e'(trig_q[i]) == TRIG_LEVEL)
        irr_nxt[i] = req_in[i];
      else
        irr_nxt[i] = irr_q[i] | (req_in[i] & ~last_q[i]);
      if (clr_en && (clr_line == LW'(i)))
        irr_nxt[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q  <= '0;
      last_q <= '0;
      trig_q <= '0;
    end else begin
      irr_q  <= irr_nxt;
      last_q <= req_in;
      if (trig_wr_en)
        trig_q <= trig_wr_data & WMASK;
    end
  end

  a_r1_reset_clean: assert property (@(posedge clk)
    $past(rst) |-> (irr_q == '0 && trig_q == '0));

  a_r5_fixed_edge: assert property (@(posedge clk) disable iff (rst)
    (trig_q & ~WMASK) == '0);

  a_r10_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> !irr_q[$past(clr_line)]);

  for (genvar g = 0; g < NLINES; g++) begin : g_line_chk
    a_r2_edge_rise: assert property (@(posedge clk) disable iff (rst)
      (!trig_q[g] && req_in[g] && !last_q[g] && !(clr_en && clr_line == LW'(g)))
      |=> irr_q[g]);
    a_r3_edge_hold: assert property (@(posedge clk) disable iff (rst)
      (!trig_q[g] && irr_q[g] && !(clr_en && clr_line == LW'(g)))
      |=> irr_q[g]);
    a_r4_level_follow: assert property (@(posedge clk) disable iff (rst)
      (trig_q[g] && !(clr_en && clr_line == LW'(g)))
      |=> (irr_q[g] == $past(req_in[g])));
  end
endmodule

// File: rtl/irqlr_prio_find.sv
module irqlr_prio_find #(
  parameter int unsigned NLINES = 8,
  localparam int unsigned LW = $clog2(NLINES)
) (
  input  logic [NLINES-1:0] vec,
  input  logic [LW-1:0]     base,
  output logic [LW:0]       rank
);
  logic [NLINES-1:0] rotated;

  for (genvar g = 0; g < NLINES; g++) begin : g_rot
    logic [LW-1:0] src;
    assign src = LW'(g) + base;
    assign rotated[g] = vec[src];
  end

  always_comb begin
    rank = (LW+1)'(NLINES);
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (rotated[i])
        rank = (LW+1)'(i);
    end
  end
endmodule

// File: rtl/irqlr_resolver.sv
module irqlr_resolver
  import irqlr_pkg::*;
#(
  parameter int unsigned NLINES = LINES_PER_UNIT,
  parameter bit IS_MASTER = 1'b1,
  parameter int unsigned CASC = CASCADE_LINE,
  localparam int unsigned LW = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] irr,
  input  logic [NLINES-1:0] irq_mask,
  input  logic [NLINES-1:0] in_service,
  input  logic [LW-1:0]     rot_offset,
  input  logic              nested_en,
  output logic              pend_valid,
  output logic [LW-1:0]     pend_line
);
  logic [NLINES-1:0] cand;
  logic [NLINES-1:0] isr_eff;
  logic [LW:0]       cand_rank;
  logic [LW:0]       serv_rank;

  assign cand = irr & ~irq_mask;

  always_comb begin
    isr_eff = in_service;
    if (IS_MASTER && nested_en)
      isr_eff[CASC] = 1'b0;
  end

  irqlr_prio_find #(.NLINES(NLINES)) u_cand_find (
    .vec(cand), .base(rot_offset), .rank(cand_rank)
  );

  irqlr_prio_find #(.NLINES(NLINES)) u_serv_find (
    .vec(isr_eff), .base(rot_offset), .rank(serv_rank)
  );

  assign pend_valid = (cand_rank != (LW+1)'(NLINES)) && (cand_rank < serv_rank);
  assign pend_line  = cand_rank[LW-1:0] + rot_offset;

  a_r6_masked_never: assert property (@(posedge clk) disable iff (rst)
    pend_valid |-> (irr[pend_line] && !irq_mask[pend_line]));

  a_r6_empty_idle: assert property (@(posedge clk) disable iff (rst)
    ((irr & ~irq_mask) == '0) |-> !pend_valid);

  a_r8_not_in_service: assert property (@(posedge clk) disable iff (rst)
    pend_valid |-> !isr_eff[pend_line]);

  a_r9_plain_ignores: assert property (@(posedge clk) disable iff (rst)
    (!nested_en && in_service == '0 && cand_rank != (LW+1)'(NLINES)) |-> pend_valid);
endmodule

// File: rtl/irq_latch_resolver.sv
module irq_latch_resolver
  import irqlr_pkg::*;
#(
  parameter int unsigned NLINES = LINES_PER_UNIT,
  parameter bit IS_MASTER = 1'b1,
  parameter logic [NLINES-1:0] TRIG_WMASK = MASTER_TRIG_WMASK,
  localparam int unsigned LW = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] req_in,
  input  logic              trig_wr_en,
  input  logic [NLINES-1:0] trig_wr_data,
  input  logic [NLINES-1:0] irq_mask,
  input  logic [NLINES-1:0] in_service,
  input  logic [LW-1:0]     rot_offset,
  input  logic              nested_en,
  input  logic              clr_en,
  input  logic [LW-1:0]     clr_line,
  output logic [NLINES-1:0] trig_mode,
  output logic [NLINES-1:0] req_latched,
  output logic              pend_valid,
  output logic [LW-1:0]     pend_line
);
  irqlr_capture #(.NLINES(NLINES), .WMASK(TRIG_WMASK)) u_capture (
    .clk(clk), .rst(rst), .req_in(req_in),
    .trig_wr_en(trig_wr_en), .trig_wr_data(trig_wr_data),
    .clr_en(clr_en), .clr_line(clr_line),
    .trig_q(trig_mode), .irr_q(req_latched)
  );

  irqlr_resolver #(.NLINES(NLINES), .IS_MASTER(IS_MASTER), .CASC(CASCADE_LINE)) u_resolver (
    .clk(clk), .rst(rst), .irr(req_latched), .irq_mask(irq_mask),
    .in_service(in_service), .rot_offset(rot_offset), .nested_en(nested_en),
    .pend_valid(pend_valid), .pend_line(pend_line)
  );
endmodule

// File: tb/tb_irq_latch_resolver.sv
module tb_irq_latch_resolver;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req_in = '0;
  logic       trig_wr_en = 1'b0;
  logic [7:0] trig_wr_data = '0;
  logic [7:0] irq_mask = '0;
  logic [7:0] in_service = '0;
  logic [2:0] rot_offset = '0;
  logic       nested_en = 1'b0;
  logic       clr_en = 1'b0;
  logic [2:0] clr_line = '0;
  logic [7:0] trig_mode, req_latched;
  logic       pend_valid;
  logic [2:0] pend_line;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_latch_resolver dut (
    .clk(clk), .rst(rst), .req_in(req_in), .trig_wr_en(trig_wr_en),
    .trig_wr_data(trig_wr_data), .irq_mask(irq_mask), .in_service(in_service),
    .rot_offset(rot_offset), .nested_en(nested_en), .clr_en(clr_en),
    .clr_line(clr_line), .trig_mode(trig_mode), .req_latched(req_latched),
    .pend_valid(pend_valid), .pend_line(pend_line)
  );

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Expected outcome: returns valid, line via outputs
  task automatic model(input logic [7:0] cand, input logic [7:0] isr,
                       input int off, input bit nst,
                       output bit v, output int ln);
    int p = 8;
    int c = 8;
    logic [7:0] eff = isr;
    if (nst) eff[2] = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (p == 8 && cand[(k + off) % 8]) p = k;
      if (c == 8 && eff[(k + off) % 8]) c = k;
    end
    v  = (p < 8) && (p < c);
    ln = (p + off) % 8;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write_trig(logic [7:0] val);
    trig_wr_en = 1'b1; trig_wr_data = val;
    step();
    trig_wr_en = 1'b0;
  endtask

  task automatic clear_line(int ln);
    clr_en = 1'b1; clr_line = 3'(ln);
    step();
    clr_en = 1'b0;
  endtask

  task automatic load_pattern(logic [7:0] pat);
    req_in = '0;
    step();
    for (int l = 0; l < 3; l++) clear_line(l);
    req_in = pat;
    step();
  endtask

  task automatic check_pend(string tag);
    bit v; int ln;
    #1;
    model(req_latched & ~irq_mask, in_service, int'(rot_offset), nested_en, v, ln);
    check({tag, " valid"}, int'(pend_valid), int'(v));
    if (v) check({tag, " line"}, int'(pend_line), ln);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst = 1'b0;
    step();
    // R1
    check("R1 irr", int'(req_latched), 0);
    check("R1 trig", int'(trig_mode), 0);
    check("R1 pend", int'(pend_valid), 0);

    // R5: write mask F8 on master
    write_trig(8'hFF);
    check("R5 all", int'(trig_mode), 8'hF8);
    write_trig(8'h07);
    check("R5 fixed", int'(trig_mode), 8'h00);
    write_trig(8'h5A);
    check("R5 mix", int'(trig_mode), 8'h58);
    write_trig(8'h00);

    // R2: edge rise on line 0
    req_in = 8'h01; step();
    check("R2 rise", int'(req_latched[0]), 1);
    clear_line(0);
    check("R10 clr edge", int'(req_latched[0]), 0);
    step();
    check("R2 held high no reset", int'(req_latched[0]), 0);
    // R3: low does not clear
    req_in = 8'h00; step();
    req_in = 8'h01; step();
    req_in = 8'h00; step();
    check("R3 low keeps", int'(req_latched[0]), 1);
    step();
    check("R3 low keeps2", int'(req_latched[0]), 1);
    clear_line(0);

    // R4: level on line 3 after enabling
    write_trig(8'hFF);
    req_in = 8'h08; step();
    check("R4 level high", int'(req_latched[3]), 1);
    req_in = 8'h00; step();
    check("R4 level low", int'(req_latched[3]), 0);

    // R10: level line 4 held high, clear drops for one edge
    req_in = 8'h10; step();
    clear_line(4);
    check("R10 level clr", int'(req_latched[4]), 0);
    step();
    check("R10 level back", int'(req_latched[4]), 1);
    // R10: edge line 1 rising together with clear
    req_in = 8'h00; step();
    req_in = 8'h02; clr_en = 1'b1; clr_line = 3'd1; step();
    clr_en = 1'b0;
    check("R10 edge clr precedence", int'(req_latched[1]), 0);

    // Directed R6/R7/R8/R9 on pattern bit 5 only
    load_pattern(8'h20);
    check("R2 R4 load", int'(req_latched), 8'h20);
    irq_mask = 8'h20; check_pend("R6 masked");
    check("R6 masked idle", int'(pend_valid), 0);
    irq_mask = 8'h00; rot_offset = 3'd6; check_pend("R7 rot");
    check("R7 rot line", int'(pend_line), 5);
    rot_offset = 3'd0; in_service = 8'h04; nested_en = 1'b0; check_pend("R8 below");
    check("R8 blocked", int'(pend_valid), 0);
    nested_en = 1'b1; check_pend("R9 nested");
    check("R9 passes", int'(pend_valid), 1);
    in_service = 8'h20; check_pend("R8 equal");
    check("R8 equal blocked", int'(pend_valid), 0);
    in_service = 8'h00; nested_en = 1'b0;

    // Sweep
    for (int pat = 0; pat < 256; pat++) begin
      load_pattern(8'(pat));
      check("R4 sweep load", int'(req_latched), pat);
      for (int mi = 0; mi < 3; mi++) begin
        irq_mask = (mi == 0) ? 8'h00 : (mi == 1) ? 8'hA5 : 8'h0F;
        for (int k = 0; k < 8; k++) begin
          in_service = 8'(k * 41);
          for (int o = 0; o < 8; o++) begin
            rot_offset = 3'(o);
            for (int n = 0; n < 2; n++) begin
              nested_en = n[0];
              check_pend("R7 R8 R9 sweep");
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule